// File: doc/BRIEF.md
# Guarded Clock Source Select Register

This block is the control register that chooses which clock drives the baud-rate and bit-timing logic of a bus controller with several nodes. It holds a 4-bit one-hot selection field. A register bus writes the field using a write strobe and byte enables. Each node supplies a configuration-enable flag, and the block returns a one-cycle pulse to each node that sets that node's init flag.

A write to the low byte always re-initialises every node. The write changes the selection only when every node has its configuration-enable flag set. The block enforces a safe switch between clock sources. A running source must first be turned off with a write of zero. The next source is accepted only after a minimum gap, counted in module-clock cycles. The gap is four periods of the old source plus two module-clock periods. It is zero when the old source is the module clock itself. A write that breaks these rules leaves the field unchanged and sets a sticky error output. The clock multiplexer and the nodes are outside this block.

Top module: `clksrc_guard_reg`

## Requirements
- R1: After reset, `clk_sel` and `rdata` are zero, `sel_err` is 0 and `node_init_set` is all zeros.
- R2: A write with `wr_en`=1 and `byte_en[0]`=1 drives `node_init_set` all ones for exactly the cycle after the write, whatever `node_cfg_en` holds. A write with `byte_en[0]`=0 produces no pulse and has no effect.
- R3: A low-byte write while any bit of `node_cfg_en` is 0 leaves `clk_sel` unchanged and does not set `sel_err`.
- R4: The field is taken from `wdata[3:0]`. The legal codes are 0000 (no clock), 0001 (module clock), 0010 (oscillator) and 0100 (PLL). Any other code, including 1000, leaves the field unchanged and sets `sel_err`.
- R5: A legal write of 0000 is always accepted and selects no clock.
- R6: A nonzero code that differs from a nonzero current selection is rejected and sets `sel_err`. Writing the current value again is accepted as a no-op and raises no error.
- R7: After 0000 replaces the oscillator (0010) or the PLL (0100), a nonzero write is accepted only if it arrives at least G clock edges after the zero write. G is 4*OSC_RATIO+2 for the oscillator and 4*PLL_RATIO+2 for the PLL. An earlier write is rejected and sets `sel_err`.
- R8: After 0000 replaces the module clock (0001), a nonzero write on the very next cycle is accepted.
- R9: `sel_err` is sticky: once set, it stays 1 until reset.
- R10: `rdata[3:0]` shows the field and `rdata[31:4]` reads zero. Write data outside bits [3:0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| byte_en | input | 4 | Byte enables of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register read value |
| node_cfg_en | input | NUM_NODES | Configuration-enable flag of each node |
| node_init_set | output | NUM_NODES | One-cycle pulse that sets each node's init flag |
| clk_sel | output | 4 | One-hot clock source selection |
| sel_err | output | 1 | Sticky rule-violation flag |

## Verification
The hardest case to reach is the exact edge of the switch-off gap. A write one cycle too early must be refused, and a write on the next cycle must be taken. To get there, the stimulus selects a source, writes zero, waits G-2 idle cycles, and then issues two writes of the new code back to back. The first write lands on edge G-1 and the second on edge G, so one sequence covers both sides of the boundary. Because the error flag is sticky, each scenario starts from a fresh reset, so that every error seen belongs to that scenario.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [3:0] {
        SRC_NONE = 4'b0000,
        SRC_MOD  = 4'b0001,
        SRC_OSC  = 4'b0010,
        SRC_PLL  = 4'b0100,
        SRC_TIED = 4'b1000
    } clk_src_e;

    typedef struct packed {
        logic [3:0] sel;
        logic       err;
    } sel_state_t;

    function automatic logic code_is_legal(input logic [3:0] code);
        return (code == SRC_NONE) || (code == SRC_MOD) ||
               (code == SRC_OSC)  || (code == SRC_PLL);
    endfunction

endpackage

// File: rtl/clksel_code_chk.sv
module clksel_code_chk
    import clksel_pkg::*;
(
    input  logic       wr_lo,
    input  logic       unlocked,
    input  logic [3:0] code,
    input  logic [3:0] cur,
    input  logic       gap_busy,
    output logic       accept,
    output logic       reject
);

    always_comb begin
        accept = 1'b0;
        reject = 1'b0;
        if (wr_lo && unlocked) begin
            if (!code_is_legal(code)) begin
                reject = 1'b1;
            end else if (code == SRC_NONE) begin
                accept = 1'b1;
            end else if (code == cur) begin
                accept = 1'b1;
            end else if (cur != SRC_NONE) begin
                reject = 1'b1;
            end else if (gap_busy) begin
                reject = 1'b1;
            end else begin
                accept = 1'b1;
            end
        end
    end

endmodule

// File: rtl/clksel_gap_timer.sv
module clksel_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    a_r7_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> busy);

endmodule

// File: rtl/clksel_init_pulse.sv
module clksel_init_pulse #(
    parameter int NUM_NODES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig,
    output logic [NUM_NODES-1:0] init_set
);

    logic [NUM_NODES-1:0] pulse_d, pulse_q;

    always_comb begin
        for (int i = 0; i < NUM_NODES; i++) begin
            pulse_d[i] = trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign init_set = pulse_q;

endmodule

// File: rtl/clksrc_guard_reg.sv
module clksrc_guard_reg
    import clksel_pkg::*;
#(
    parameter int NUM_NODES = 4,
    parameter int OSC_RATIO = 3,
    parameter int PLL_RATIO = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           byte_en,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_NODES-1:0] node_cfg_en,
    output logic [NUM_NODES-1:0] node_init_set,
    output logic [3:0]           clk_sel,
    output logic                 sel_err
);

    localparam int OSC_GAP = 4 * OSC_RATIO + 2;
    localparam int PLL_GAP = 4 * PLL_RATIO + 2;
    localparam int MAX_GAP = (OSC_GAP > PLL_GAP) ? OSC_GAP : PLL_GAP;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    sel_state_t st_d, st_q;
    logic             wr_lo;
    logic             unlocked;
    logic             accept;
    logic             reject;
    logic             gap_busy;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             unused_bits;

    assign wr_lo       = wr_en && byte_en[0];
    assign unlocked    = &node_cfg_en;
    assign unused_bits = ^{wdata[31:4], byte_en[3:1]};

    clksel_code_chk i_chk (
        .wr_lo    (wr_lo),
        .unlocked (unlocked),
        .code     (wdata[3:0]),
        .cur      (st_q.sel),
        .gap_busy (gap_busy),
        .accept   (accept),
        .reject   (reject)
    );

    always_comb begin
        gap_load = accept && (wdata[3:0] == SRC_NONE) && (st_q.sel != SRC_NONE);
        case (st_q.sel)
            SRC_OSC: gap_val = CNT_W'(OSC_GAP - 1);
            SRC_PLL: gap_val = CNT_W'(PLL_GAP - 1);
            default: gap_val = '0;
        endcase
    end

    clksel_gap_timer #(.CNT_W(CNT_W)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .busy     (gap_busy)
    );

    clksel_init_pulse #(.NUM_NODES(NUM_NODES)) i_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (wr_lo),
        .init_set (node_init_set)
    );

    always_comb begin
        st_d = st_q;
        if (accept) st_d.sel = wdata[3:0];
        if (reject) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_sel = st_q.sel;
    assign sel_err = st_q.err;
    assign rdata   = {28'd0, st_q.sel};

    a_r4_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_sel) && !clk_sel[3]);

    a_r6_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != SRC_NONE) |=> (clk_sel == $past(clk_sel) || clk_sel == SRC_NONE));

    a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !unlocked) |=> $stable(clk_sel));

    a_r2_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (&node_init_set));

    a_r2_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> (node_init_set == '0));

    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SRC_NONE && gap_busy) |=> (clk_sel == SRC_NONE));

    a_r9_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

endmodule

// File: tb/test_clksrc_guard_reg.sv
module test_clksrc_guard_reg;

    localparam int NN      = 4;
    localparam int OSC_R   = 3;
    localparam int PLL_R   = 1;
    localparam int OSC_G   = 4 * OSC_R + 2;
    localparam int PLL_G   = 4 * PLL_R + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    byte_en = 4'h0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NN-1:0] node_cfg_en = '1;
    logic [NN-1:0] node_init_set;
    logic [3:0]    clk_sel;
    logic          sel_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clksrc_guard_reg #(.NUM_NODES(NN), .OSC_RATIO(OSC_R), .PLL_RATIO(PLL_R)) i_clksrc_guard_reg (
        .clk, .rst_n, .wr_en, .byte_en, .wdata, .rdata,
        .node_cfg_en, .node_init_set, .clk_sel, .sel_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        node_cfg_en = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1;
        byte_en = be;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        byte_en = 4'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 clk_sel", 32'(clk_sel), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 sel_err", 32'(sel_err), 32'h0);
        chk("R1 node_init_set", 32'(node_init_set), 32'h0);
    endtask

    task automatic t_lock_and_init();
        do_reset();
        node_cfg_en = 4'b1011;
        wr(32'h1, 4'b0001);
        chk("R2 pulse while locked", 32'(node_init_set), 32'hF);
        chk("R3 locked write ignored", 32'(clk_sel), 32'h0);
        chk("R3 no error when locked", 32'(sel_err), 32'h0);
        idle(1);
        chk("R2 pulse one cycle", 32'(node_init_set), 32'h0);
        node_cfg_en = '1;
        wr(32'h1, 4'b1110);
        chk("R2 no pulse without byte 0", 32'(node_init_set), 32'h0);
        chk("R2 upper-byte write no effect", 32'(clk_sel), 32'h0);
    endtask

    task automatic t_swap_rules();
        do_reset();
        wr(32'h1, 4'b0001);
        chk("R5 select module clock", 32'(clk_sel), 32'h1);
        wr(32'h1, 4'b0001);
        chk("R6 rewrite same value", 32'(sel_err), 32'h0);
        wr(32'h2, 4'b0001);
        chk("R6 direct swap rejected", 32'(clk_sel), 32'h1);
        chk("R6 direct swap error", 32'(sel_err), 32'h1);
    endtask

    task automatic t_codes_and_sticky();
        do_reset();
        wr(32'hFFFF_FF02, 4'b1111);
        chk("R10 upper data ignored", rdata, 32'h2);
        wr(32'h8, 4'b0001);
        chk("R4 tied code rejected", 32'(clk_sel), 32'h2);
        chk("R4 tied code error", 32'(sel_err), 32'h1);
        wr(32'h0, 4'b0001);
        chk("R5 zero accepted", 32'(clk_sel), 32'h0);
        chk("R9 error sticky", 32'(sel_err), 32'h1);
        do_reset();
        wr(32'h3, 4'b0001);
        chk("R4 multi-hot rejected", 32'(clk_sel), 32'h0);
        chk("R4 multi-hot error", 32'(sel_err), 32'h1);
    endtask

    task automatic t_mod_no_gap();
        do_reset();
        wr(32'h1, 4'b0001);
        wr(32'h0, 4'b0001);
        wr(32'h4, 4'b0001);
        chk("R8 immediate switch", 32'(clk_sel), 32'h4);
        chk("R8 no error", 32'(sel_err), 32'h0);
    endtask

    task automatic t_gap(input logic [3:0] old_src, input logic [3:0] new_src, input int g);
        do_reset();
        wr(32'(old_src), 4'b0001);
        wr(32'h0, 4'b0001);
        idle(g - 2);
        wr(32'(new_src), 4'b0001);
        chk("R7 early write rejected", 32'(clk_sel), 32'h0);
        chk("R7 early write error", 32'(sel_err), 32'h1);
        wr(32'(new_src), 4'b0001);
        chk("R7 write at gap accepted", 32'(clk_sel), 32'(new_src));
    endtask

    initial begin
        t_reset_state();
        t_lock_and_init();
        t_swap_rules();
        t_codes_and_sticky();
        t_mod_no_gap();
        t_gap(4'h2, 4'h4, OSC_G);
        t_gap(4'h4, 4'h2, PLL_G);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule